// File: doc/BRIEF.md
# Threshold-Triggered Zero-Suppression Packetizer

This block sits on a digitizer's sample stream, which arrives as one wide word per clock (3.2 ns per word in the target system) holding several samples. Every sample in the word is compared against a programmable threshold. Words that lie far from any trigger event are dropped. Around each event the block emits a packet of whole clock words. A packet opens with a header word and then carries the data words back to back, with a valid flag and a last marker.

A small circular history holds recent words. The packet can therefore start a programmable number of precursor cycles before the trigger word. In edge mode the packet has a fixed length. In level mode the length depends on the data: the packet runs on while any sample stays above the threshold, and then for a programmed number of trailing cycles.

A trigger that arrives while a packet is still open lengthens that packet. It never starts a second, overlapping one. Threshold, precursor, length and mode are sampled when a packet starts and are held fixed until the packet ends.

Top module: `zsp_packetizer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, outValid is low.
- R2: Lane i of sampleWord sits in bits [i*SW +: SW]. Lane 0 is the earliest sample, and the previous word's top lane comes just before it. In edge mode a trigger fires when some sample is strictly greater than cfgThreshold and the sample before it is less than or equal to cfgThreshold.
- R3: Say an idle block sees a trigger in the word with timestamp c. The header is then valid in the next cycle. It is followed, with no gaps, by the P+L+1 data words with timestamps c-P through c+L, in order. Data word k appears k+1 cycles after the header.
- R4: The header word carries the trigger timestamp in bits [15:0], the length L in [19:16], the precursor P in [22:20] and the mode in [23] (1 = level). All higher bits are zero, and outHeader is high only on this word.
- R5: In level mode, any sample above the threshold opens a packet. Each later word with a sample above the threshold moves the end to that word's timestamp plus L. N consecutive words above the threshold, with none near them, give P+N+L data words.
- R6: An edge trigger at timestamp c' while a packet is open moves its end to c'+L. This also applies in the cycle that would otherwise emit the last word. The packet keeps its single header.
- R7: outLast is high on the final data word of a packet and on no other word. After it, outValid stays low until the next header. A trigger in the very next cycle starts a new packet at once, and its precursor words may repeat words that were already sent.
- R8: Changes to cfgThreshold, cfgPrecursor, cfgLength or cfgLevelMode while a packet is open do not affect that packet: its header, its length and how it is extended stay as they were.
- R9: In edge mode, samples that stay above the threshold across lanes and words, with no crossing, do not trigger and do not extend a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-word clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleWord | input | LANES*SW | One clock word of samples, lane 0 earliest |
| cfgThreshold | input | SW | Trigger threshold (unsigned) |
| cfgPrecursor | input | clog2(PRE_MAX+1) | Words sent before the trigger word |
| cfgLength | input | clog2(LEN_MAX+1) | Words sent after the trigger or after the last word above threshold |
| cfgLevelMode | input | 1 | 1 = level mode, 0 = edge mode |
| outValid | output | 1 | Output word valid |
| outHeader | output | 1 | Output word is a packet header |
| outLast | output | 1 | Output word is the last data word of its packet |
| outData | output | LANES*SW | Header or data word |

## Verification
A read pointer that slips by one shows up at once on the first data word after a header: the wrong timestamp's samples appear there, and the word-by-word comparison against the driven history catches it. A wrong end index, or a wrong extension decision, changes the number of words and moves outLast. The count check at the end of each packet catches this, and an outLast that is missing or comes early fails within that packet. A wrong lane-ordering or crossing decision appears as an extra or missing header within a cycle of the word that caused it.

// File: rtl/zsp_pkg.sv
package zsp_pkg;

  // Packet sequencer state
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } zsp_state_e;

  // Strobes from the sequencer to the datapath, one set per clock
  typedef struct packed {
    logic emitHdr;
    logic emitData;
    logic emitLast;
  } zsp_strobe_t;

endpackage

// File: rtl/zsp_datapath.sv
module zsp_datapath
  import zsp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SW    = 8,
  parameter int TSW   = 16,
  parameter int PW    = 3,
  parameter int LW    = 4,
  parameter int AW    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LANES*SW-1:0]   sampleWord,
  input  logic [SW-1:0]         thr,
  input  logic                  levelMode,
  input  logic [PW-1:0]         hdrPre,
  input  logic [LW-1:0]         hdrLen,
  input  zsp_strobe_t           strobe,
  input  logic [AW-1:0]         rdAddr,
  output logic                  trigHit,
  output logic [TSW-1:0]        tsNow,
  output logic                  outValid,
  output logic                  outHeader,
  output logic                  outLast,
  output logic [LANES*SW-1:0]   outData
);

  localparam int DW    = LANES * SW;
  localparam int DEPTH = 1 << AW;

  logic [SW-1:0]    prevLast;
  logic [LANES-1:0] aboveVec;
  logic [LANES-1:0] crossVec;
  logic [DW-1:0]    histMem [DEPTH];
  logic [DW-1:0]    hdrWord;

  // Per-lane compare; each lane looks at its predecessor in time
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SW-1:0] cur;
    logic [SW-1:0] prv;
    assign cur = sampleWord[g*SW +: SW];
    if (g == 0) begin : g_first
      assign prv = prevLast;
    end else begin : g_rest
      assign prv = sampleWord[(g-1)*SW +: SW];
    end
    assign aboveVec[g] = cur > thr;
    assign crossVec[g] = (cur > thr) && (prv <= thr);
  end

  assign trigHit = levelMode ? (|aboveVec) : (|crossVec);
  assign hdrWord = DW'({levelMode, hdrPre, hdrLen, tsNow});

  // Timestamp counter, carry-over sample and history ring
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsNow    <= '0;
      prevLast <= '0;
      for (int i = 0; i < DEPTH; i++) histMem[i] <= '0;
    end else begin
      tsNow                  <= tsNow + TSW'(1);
      prevLast               <= sampleWord[(LANES-1)*SW +: SW];
      histMem[tsNow[AW-1:0]] <= sampleWord;
    end
  end

  // Output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outHeader <= 1'b0;
      outLast   <= 1'b0;
      outData   <= '0;
    end else begin
      outValid  <= strobe.emitHdr | strobe.emitData;
      outHeader <= strobe.emitHdr;
      outLast   <= strobe.emitLast;
      outData   <= strobe.emitHdr ? hdrWord : histMem[rdAddr];
    end
  end

endmodule

// File: rtl/zsp_control.sv
module zsp_control
  import zsp_pkg::*;
#(
  parameter int SW  = 8,
  parameter int TSW = 16,
  parameter int PW  = 3,
  parameter int LW  = 4,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           trigHit,
  input  logic [TSW-1:0] tsNow,
  input  logic [SW-1:0]  cfgThreshold,
  input  logic [PW-1:0]  cfgPrecursor,
  input  logic [LW-1:0]  cfgLength,
  input  logic           cfgLevelMode,
  output zsp_strobe_t    strobe,
  output logic [AW-1:0]  rdAddr,
  output logic [SW-1:0]  effThr,
  output logic           effLevel,
  output logic [PW-1:0]  effPre,
  output logic [LW-1:0]  effLen
);

  zsp_state_e     state;
  logic [SW-1:0]  latThr;
  logic [PW-1:0]  latPre;
  logic [LW-1:0]  latLen;
  logic           latLevel;
  logic [TSW-1:0] rdIdx;
  logic [TSW-1:0] endIdx;
  logic           busy;
  logic           atEnd;

  assign busy  = (state == ST_BUSY);
  assign atEnd = (rdIdx == endIdx);

  // Settings follow the inputs only while idle
  assign effThr   = busy ? latThr   : cfgThreshold;
  assign effLevel = busy ? latLevel : cfgLevelMode;
  assign effPre   = busy ? latPre   : cfgPrecursor;
  assign effLen   = busy ? latLen   : cfgLength;

  assign strobe.emitHdr  = !busy && trigHit;
  assign strobe.emitData = busy;
  assign strobe.emitLast = busy && !trigHit && atEnd;
  assign rdAddr          = rdIdx[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      latThr   <= '0;
      latPre   <= '0;
      latLen   <= '0;
      latLevel <= 1'b0;
      rdIdx    <= '0;
      endIdx   <= '0;
    end else if (!busy) begin
      if (trigHit) begin
        state    <= ST_BUSY;
        latThr   <= cfgThreshold;
        latPre   <= cfgPrecursor;
        latLen   <= cfgLength;
        latLevel <= cfgLevelMode;
        rdIdx    <= tsNow - TSW'(cfgPrecursor);
        endIdx   <= tsNow + TSW'(cfgLength);
      end
    end else begin
      rdIdx <= rdIdx + TSW'(1);
      if (trigHit) begin
        endIdx <= tsNow + TSW'(latLen);
      end else if (atEnd) begin
        state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/zsp_packetizer.sv
module zsp_packetizer
  import zsp_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SW      = 8,
  parameter int PRE_MAX = 7,
  parameter int LEN_MAX = 15,
  parameter int TSW     = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [LANES*SW-1:0]             sampleWord,
  input  logic [SW-1:0]                   cfgThreshold,
  input  logic [$clog2(PRE_MAX+1)-1:0]    cfgPrecursor,
  input  logic [$clog2(LEN_MAX+1)-1:0]    cfgLength,
  input  logic                            cfgLevelMode,
  output logic                            outValid,
  output logic                            outHeader,
  output logic                            outLast,
  output logic [LANES*SW-1:0]             outData
);

  localparam int PW = $clog2(PRE_MAX + 1);
  localparam int LW = $clog2(LEN_MAX + 1);
  localparam int AW = $clog2(PRE_MAX + 3);

  zsp_strobe_t    strobe;
  logic [AW-1:0]  rdAddr;
  logic           trigHit;
  logic [TSW-1:0] tsNow;
  logic [SW-1:0]  effThr;
  logic           effLevel;
  logic [PW-1:0]  effPre;
  logic [LW-1:0]  effLen;

  zsp_control #(
    .SW(SW), .TSW(TSW), .PW(PW), .LW(LW), .AW(AW)
  ) i_control (
    .clk          (clk),
    .rstN         (rstN),
    .trigHit      (trigHit),
    .tsNow        (tsNow),
    .cfgThreshold (cfgThreshold),
    .cfgPrecursor (cfgPrecursor),
    .cfgLength    (cfgLength),
    .cfgLevelMode (cfgLevelMode),
    .strobe       (strobe),
    .rdAddr       (rdAddr),
    .effThr       (effThr),
    .effLevel     (effLevel),
    .effPre       (effPre),
    .effLen       (effLen)
  );

  zsp_datapath #(
    .LANES(LANES), .SW(SW), .TSW(TSW), .PW(PW), .LW(LW), .AW(AW)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .sampleWord (sampleWord),
    .thr        (effThr),
    .levelMode  (effLevel),
    .hdrPre     (effPre),
    .hdrLen     (effLen),
    .strobe     (strobe),
    .rdAddr     (rdAddr),
    .trigHit    (trigHit),
    .tsNow      (tsNow),
    .outValid   (outValid),
    .outHeader  (outHeader),
    .outLast    (outLast),
    .outData    (outData)
  );

endmodule

// File: rtl/zsp_checker.sv
module zsp_checker (
  input logic clk,
  input logic rstN,
  input logic outValid,
  input logic outHeader,
  input logic outLast
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !outValid);

  // R3
  hdr_then_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHeader) |=> (outValid && !outHeader));

  // R3
  data_contiguous_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outHeader) |-> $past(outValid));

  // R7
  last_on_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (outValid && !outHeader));

  // R7
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |=> !(outValid && !outHeader));

endmodule

bind zsp_packetizer zsp_checker i_zspChk (
  .clk       (clk),
  .rstN      (rstN),
  .outValid  (outValid),
  .outHeader (outHeader),
  .outLast   (outLast)
);

// File: tb/test_zsp_packetizer.sv
module test_zsp_packetizer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] sampleWord = '0;
  logic [7:0]  cfgThreshold = 8'h80;
  logic [2:0]  cfgPrecursor = '0;
  logic [3:0]  cfgLength = '0;
  logic        cfgLevelMode = 1'b0;
  logic        outValid, outHeader, outLast;
  logic [31:0] outData;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  int tsB = 0;

  logic [31:0] hist [1024];
  logic [31:0] capData [2048];
  bit          capHdr [2048];
  bit          capLast [2048];
  int          capEdge [2048];
  int          capN = 0;
  int          capIdx = 0;

  always #5 clk = ~clk;

  zsp_packetizer i_zsp_packetizer (
    .clk(clk), .rstN(rstN), .sampleWord(sampleWord),
    .cfgThreshold(cfgThreshold), .cfgPrecursor(cfgPrecursor),
    .cfgLength(cfgLength), .cfgLevelMode(cfgLevelMode),
    .outValid(outValid), .outHeader(outHeader), .outLast(outLast),
    .outData(outData)
  );

  always @(posedge clk) if (rstN) tsB <= tsB + 1;

  // Capture every valid output word, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN && outValid && capN < 2048) begin
      capData[capN] = outData;
      capHdr[capN]  = outHeader;
      capLast[capN] = outLast;
      capEdge[capN] = tsB - 1;
      capN++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bgWord(input int ts);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) w[j*8 +: 8] = 8'((ts * 4 + j) & 63);
    return w;
  endfunction

  function automatic logic [31:0] pulseWord(input int ts, input logic [3:0] mask);
    logic [31:0] w;
    w = bgWord(ts);
    for (int j = 0; j < 4; j++) if (mask[j]) w[j*8 +: 8] = 8'hC0 | 8'(j);
    return w;
  endfunction

  task automatic drive(input logic [31:0] w);
    sampleWord = w;
    hist[tsB & 1023] = w;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(bgWord(tsB));
  endtask

  task automatic pulse(input logic [3:0] mask);
    drive(pulseWord(tsB, mask));
  endtask

  task automatic expectPacket(input int trig, input int pre, input int len,
                              input bit lvl, input int nWords, input string req);
    int base;
    bit dataOk;
    bit lastOk;
    int bad;
    logic [31:0] expH;
    base = capIdx;
    if (capN < base + nWords + 1) begin
      chk(0, req, "captured word count", capN - base, nWords + 1);
      capIdx = capN;
      return;
    end
    expH = {8'h00, lvl, 3'(pre), 4'(len), 16'(trig)};
    chk(capHdr[base] && capEdge[base] == trig, "R3", "header cycle",
        capEdge[base], trig);
    chk(capData[base] == expH, "R4", "header word", capData[base], expH);
    dataOk = 1;
    lastOk = 1;
    bad = 0;
    for (int k = 0; k < nWords; k++) begin
      int idx;
      idx = base + 1 + k;
      if (capHdr[idx] || capEdge[idx] != trig + 1 + k ||
          capData[idx] != hist[(trig - pre + k) & 1023]) begin
        if (dataOk) bad = k;
        dataOk = 0;
      end
      if (capLast[idx] != (k == nWords - 1)) lastOk = 0;
    end
    chk(dataOk, req, "data word mismatch at index", bad,
        hist[(trig - pre + bad) & 1023]);
    chk(lastOk, "R7", "last marker placement", 0, 1);
    capIdx = base + nWords + 1;
  endtask

  task automatic endGroup(input string req);
    chk(capN == capIdx, req, "extra output words", capN, capIdx);
    chk(outValid == 1'b0, "R7", "valid after packets", outValid, 0);
  endtask

  initial begin
    #(60000 * 10);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int trig;
    @(negedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "valid in reset", outValid, 0);
    rstN = 1'b1;
    idle(1);
    chk(outValid == 1'b0, "R1", "valid after reset", outValid, 0);
    idle(12);

    // R2 R3: edge sweep over precursor, length and crossing lane
    cfgLevelMode = 1'b0;
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 4; l++)
        for (int lane = 0; lane < 4; lane++) begin
          cfgPrecursor = 3'(p);
          cfgLength = 4'(l);
          idle(2);
          capIdx = capN;
          trig = tsB;
          pulse(4'b0001 << lane);
          idle(p + l + 4);
          expectPacket(trig, p, l, 0, p + l + 1, "R3");
          endGroup("R2");
        end

    // R5: level sweep
    cfgLevelMode = 1'b1;
    for (int p = 0; p < 3; p++)
      for (int l = 0; l < 3; l++)
        for (int n = 1; n <= 4; n++) begin
          cfgPrecursor = 3'(p);
          cfgLength = 4'(l);
          idle(2);
          capIdx = capN;
          trig = tsB;
          for (int k = 0; k < n; k++) pulse(k == 0 ? 4'b1111 : (4'b0001 << (k % 4)));
          idle(p + l + 4);
          expectPacket(trig, p, l, 1, p + n + l, "R5");
          endGroup("R5");
        end

    // R9: staying high across lanes and words gives no new crossing
    cfgLevelMode = 1'b0;
    cfgPrecursor = 3'd0;
    cfgLength = 4'd0;
    idle(3);
    capIdx = capN;
    trig = tsB;
    pulse(4'b1010);
    pulse(4'b1111);
    pulse(4'b1111);
    idle(5);
    expectPacket(trig, 0, 0, 0, 1, "R9");
    endGroup("R9");

    // R6: extension by a second crossing
    cfgPrecursor = 3'd1;
    cfgLength = 4'd3;
    idle(3);
    capIdx = capN;
    trig = tsB;
    pulse(4'b0010);
    idle(1);
    pulse(4'b0010);
    idle(10);
    expectPacket(trig, 1, 3, 0, 7, "R6");
    endGroup("R6");

    // R6: crossing in the cycle that would emit the last word
    idle(2);
    capIdx = capN;
    trig = tsB;
    pulse(4'b0100);
    idle(4);
    pulse(4'b0100);
    idle(10);
    expectPacket(trig, 1, 3, 0, 10, "R6");
    endGroup("R6");

    // R7: crossing one cycle later starts a fresh packet back to back
    idle(2);
    capIdx = capN;
    trig = tsB;
    pulse(4'b1000);
    idle(5);
    pulse(4'b1000);
    idle(10);
    expectPacket(trig, 1, 3, 0, 5, "R7");
    expectPacket(trig + 6, 1, 3, 0, 5, "R7");
    endGroup("R7");

    // R8: settings changed mid-packet are ignored by that packet
    cfgPrecursor = 3'd2;
    cfgLength = 4'd4;
    idle(3);
    capIdx = capN;
    trig = tsB;
    pulse(4'b0001);
    cfgPrecursor = 3'd0;
    cfgLength = 4'd0;
    cfgThreshold = 8'hFF;
    cfgLevelMode = 1'b1;
    idle(1);
    pulse(4'b0001);
    idle(12);
    expectPacket(trig, 2, 4, 0, 9, "R8");
    endGroup("R8");
    cfgThreshold = 8'h80;
    cfgLevelMode = 1'b0;
    idle(3);
    endGroup("R8");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule